// File: doc/BRIEF.md
# BCD Real-Time Clock Register File

This block keeps calendar time in a set of internal BCD counters that advance on a one-cycle 1 Hz strobe. The counters cover seconds, minutes, hours, day of week, day of month, month, a two-digit year and a century byte, so the full year is century×100 + year. Software never reads the counters directly. It reads a bank of user-visible registers that are reloaded from the counters once per second, in the cycle after the counters step.

Each register sits at its own offset from the block's base, on a byte-wide bus with separate write and read strobes. A hold bit in the control register stops the once-per-second reload. Software sets it to read a consistent time, or to load a new time and commit that time to the counters when it clears the bit. The counters keep running while the hold bit is set. An alarm section compares seconds, minutes, hours and day of month against four alarm registers. It sets a flag that a read clears, and it drives an interrupt while that flag and the alarm interrupt enable are both set.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the visible time reads sec 00, min 00, hr 00, dow 01, dom 01, mon 01, year 00, century 20, with control 0x04, enables 0x00, flags 0x00, all alarm registers 0x00, and alarm_irq low. Offsets are: 0 sec, 1 min, 2 hr, 3 dow, 4 dom, 5 mon, 6 year, 7 century, 8 alarm sec, 9 alarm min, 10 alarm hr, 11 alarm dom, 12 enables, 13 flags, 14 control.
- R2: A bus read is registered, and bus_rdata holds the value after the clock edge that samples bus_rd. When tick_1hz is high at an edge and the run bit is set, the counters advance by one second. The visible registers show the new value from the second edge onward.
- R3: A new time is loaded by setting the hold bit, writing offsets 0 to 7 and then writing control with the hold bit clear. That last write copies the written values into the counters, and later ticks count on from them.
- R4: While the hold bit is 1, ticks do not change the visible registers, but the counters keep advancing. If the bit is cleared with no time writes in between, the counters are left alone and the next tick shows the true time.
- R5: Carries ripple from seconds to minutes to hours to day to month to year to century. Seconds and minutes wrap 59→00, hours wrap 23→00, month wraps 12→01, and year and century wrap 99→00.
- R6: Day of month wraps to 01 after the last day of its month: 30 for months 04, 06, 09 and 11, 31 for the others, and for month 02 either 29 when the two-digit year is divisible by 4 or 28 otherwise. Day of week wraps 07→01.
- R7: A reload already under way completes. If the hold bit is written to 1 in the cycle right after a tick edge, that second's reload still reaches the visible registers.
- R8: Writes to offsets 0 to 7 while the hold bit is 0 have no effect on the visible registers or on the counters.
- R9: Control bit 0 is daylight-saving enable and bit 1 is 24-hour mode. Both are stored and read back only, and hours always count 00 to 23. Bit 2 is run and bit 3 is hold. Bits 7 to 4 read 0. While run is 0 the counters do not advance.
- R10: After each counter advance, if seconds, minutes, hours and day of month equal the four alarm registers, flags bit 3 is set. A read of the flags register returns the flag and clears it, unless a match sets it in that same cycle.
- R11: Enables bit 3 is the alarm interrupt enable and bit 2 is a second alarm enable that is stored only. Other enable bits read 0. alarm_irq is high exactly while the flag and enables bit 3 are both 1.
- R12: Reads of offsets 15 and above, including any address with a bit set above bit 3, return 0x00, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| bus_addr | input | ADDR_W | Register address (offset from base) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| alarm_irq | output | 1 | Registered alarm interrupt |

## Verification
Corrupt counter state stays out of sight while the hold bit is set. It shows up on the next tick after release as a wrong seconds value, and only at a rollover as a wrong carry into minutes, days, months or the century. A lost commit or a stray commit shows up on the first read after the hold bit clears. A reload missed during a freeze shows up on the read right after it. A flag or interrupt in the wrong state shows on alarm_irq in the cycle of the matching second, and on the flags read that follows.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;
  localparam int OFS_W       = 4;
  localparam int TIME_FIELDS = 8;
  localparam int ALM_FIELDS  = 4;

  typedef logic [7:0] bcd8_t;

  // sec occupies the low byte so field index i equals its bus offset
  typedef struct packed {
    bcd8_t cen;
    bcd8_t yr;
    bcd8_t mon;
    bcd8_t dom;
    bcd8_t dow;
    bcd8_t hr;
    bcd8_t min;
    bcd8_t sec;
  } rtc_time_t;

  localparam logic [OFS_W-1:0] OFS_SEC  = 4'h0;
  localparam logic [OFS_W-1:0] OFS_MIN  = 4'h1;
  localparam logic [OFS_W-1:0] OFS_HR   = 4'h2;
  localparam logic [OFS_W-1:0] OFS_DOW  = 4'h3;
  localparam logic [OFS_W-1:0] OFS_DOM  = 4'h4;
  localparam logic [OFS_W-1:0] OFS_MON  = 4'h5;
  localparam logic [OFS_W-1:0] OFS_YR   = 4'h6;
  localparam logic [OFS_W-1:0] OFS_CEN  = 4'h7;
  localparam logic [OFS_W-1:0] OFS_ASEC = 4'h8;
  localparam logic [OFS_W-1:0] OFS_AMIN = 4'h9;
  localparam logic [OFS_W-1:0] OFS_AHR  = 4'hA;
  localparam logic [OFS_W-1:0] OFS_ADOM = 4'hB;
  localparam logic [OFS_W-1:0] OFS_ENA  = 4'hC;
  localparam logic [OFS_W-1:0] OFS_FLG  = 4'hD;
  localparam logic [OFS_W-1:0] OFS_CTL  = 4'hE;

  localparam int CTL_DST  = 0;
  localparam int CTL_H24  = 1;
  localparam int CTL_RUN  = 2;
  localparam int CTL_HOLD = 3;
  localparam int ENA_ABE  = 2;
  localparam int ENA_AIE  = 3;
  localparam int FLG_ALM  = 3;

  localparam bcd8_t     CTL_RESET  = 8'h04;
  localparam rtc_time_t RESET_TIME = '{cen: 8'h20, yr: 8'h00, mon: 8'h01, dom: 8'h01,
                                       dow: 8'h01, hr: 8'h00, min: 8'h00, sec: 8'h00};

  function automatic bcd8_t bcd_inc(input bcd8_t v);
    bcd8_t r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // two-digit BCD year divisible by 4
  function automatic logic year_div4(input bcd8_t y);
    logic r;
    if (y[4]) r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return r;
  endfunction

  function automatic bcd8_t month_last(input bcd8_t m, input bcd8_t y);
    bcd8_t r;
    case (m)
      8'h02:                      r = year_div4(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bcd_rtc_calendar.sv
module bcd_rtc_calendar
  import bcd_rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      step,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t now
);
  rtc_time_t nxt;
  logic c_min, c_hr, c_day, c_mon, c_yr, c_cen;

  always_comb begin
    nxt   = now;
    c_min = (now.sec == 8'h59);
    c_hr  = c_min && (now.min == 8'h59);
    c_day = c_hr  && (now.hr  == 8'h23);
    c_mon = c_day && (now.dom == month_last(now.mon, now.yr));
    c_yr  = c_mon && (now.mon == 8'h12);
    c_cen = c_yr  && (now.yr  == 8'h99);

    nxt.sec = c_min ? 8'h00 : bcd_inc(now.sec);
    if (c_min) nxt.min = (now.min == 8'h59) ? 8'h00 : bcd_inc(now.min);
    if (c_hr)  nxt.hr  = (now.hr  == 8'h23) ? 8'h00 : bcd_inc(now.hr);
    if (c_day) begin
      nxt.dow = (now.dow == 8'h07) ? 8'h01 : bcd_inc(now.dow);
      nxt.dom = c_mon ? 8'h01 : bcd_inc(now.dom);
    end
    if (c_mon) nxt.mon = c_yr ? 8'h01 : bcd_inc(now.mon);
    if (c_yr)  nxt.yr  = c_cen ? 8'h00 : bcd_inc(now.yr);
    if (c_cen) nxt.cen = (now.cen == 8'h99) ? 8'h00 : bcd_inc(now.cen);
  end

  always_ff @(posedge clk) begin
    if (rst)       now <= RESET_TIME;
    else if (load) now <= load_val;
    else if (step) now <= nxt;
  end
endmodule

// File: rtl/bcd_rtc_view.sv
module bcd_rtc_view
  import bcd_rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] ofs,
  input  bcd8_t            wdata,
  input  logic             step,
  input  rtc_time_t        now,
  output rtc_time_t        shown,
  output bcd8_t            ctl_q,
  output logic             commit,
  output logic             pend_q,
  output logic             refresh
);
  localparam logic [OFS_W-1:0] TIME_LIMIT = OFS_W'(TIME_FIELDS);

  logic [TIME_FIELDS-1:0][7:0] now_a;
  logic [TIME_FIELDS-1:0][7:0] shown_a;
  logic [7:0] fld_q [TIME_FIELDS];
  logic copy_ok_q, dirty_q, hold, ctl_wr, time_wr;

  assign now_a   = now;
  assign hold    = ctl_q[CTL_HOLD];
  assign ctl_wr  = wr_en && (ofs == OFS_CTL);
  assign time_wr = wr_en && hold && (ofs < TIME_LIMIT);
  assign commit  = ctl_wr && hold && !wdata[CTL_HOLD] && dirty_q;
  assign refresh = pend_q && copy_ok_q;

  for (genvar i = 0; i < TIME_FIELDS; i++) begin : g_fld
    localparam logic [OFS_W-1:0] MY_OFS = OFS_W'(i);
    always_ff @(posedge clk) begin
      if (rst)                           fld_q[i] <= RESET_TIME[8*i +: 8];
      else if (time_wr && ofs == MY_OFS) fld_q[i] <= wdata;
      else if (refresh)                  fld_q[i] <= now_a[i];
    end
  end

  always_comb begin
    for (int i = 0; i < TIME_FIELDS; i++) shown_a[i] = fld_q[i];
  end
  assign shown = shown_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= CTL_RESET;
      pend_q    <= 1'b0;
      copy_ok_q <= 1'b0;
      dirty_q   <= 1'b0;
    end else begin
      if (ctl_wr) ctl_q <= {4'b0000, wdata[3:0]};
      pend_q    <= step;
      copy_ok_q <= step && !hold;
      if (ctl_wr && !wdata[CTL_HOLD]) dirty_q <= 1'b0;
      else if (time_wr)               dirty_q <= 1'b1;
    end
  end
endmodule

// File: rtl/bcd_rtc_alarm.sv
module bcd_rtc_alarm
  import bcd_rtc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [OFS_W-1:0]            ofs,
  input  bcd8_t                       wdata,
  input  logic                        flag_rd,
  input  logic                        check,
  input  rtc_time_t                   now,
  output logic [ALM_FIELDS-1:0][7:0]  alm_o,
  output logic [1:0]                  ena_q,
  output logic                        flag_q,
  output logic                        hit,
  output logic                        irq_q
);
  logic [ALM_FIELDS-1:0][7:0] now_f;
  logic [7:0]                 alm_q [ALM_FIELDS];
  logic [ALM_FIELDS-1:0]      eq;
  logic                       ena_wr, flag_d, aie_d;

  assign now_f = {now.dom, now.hr, now.min, now.sec};

  for (genvar i = 0; i < ALM_FIELDS; i++) begin : g_cmp
    localparam logic [OFS_W-1:0] MY_OFS = OFS_ASEC + OFS_W'(i);
    always_ff @(posedge clk) begin
      if (rst)                         alm_q[i] <= 8'h00;
      else if (wr_en && ofs == MY_OFS) alm_q[i] <= wdata;
    end
    assign eq[i] = (alm_q[i] == now_f[i]);
  end

  always_comb begin
    for (int i = 0; i < ALM_FIELDS; i++) alm_o[i] = alm_q[i];
  end

  assign ena_wr = wr_en && (ofs == OFS_ENA);
  assign hit    = check && (&eq);
  assign flag_d = hit ? 1'b1 : (flag_rd ? 1'b0 : flag_q);
  assign aie_d  = ena_wr ? wdata[ENA_AIE] : ena_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ena_q  <= 2'b00;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (ena_wr) ena_q <= {wdata[ENA_AIE], wdata[ENA_ABE]};
      flag_q <= flag_d;
      irq_q  <= flag_d && aie_d;
    end
  end
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import bcd_rtc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              alarm_irq
);
  logic                       in_page, wr_en, rd_en, flag_rd, step;
  logic [OFS_W-1:0]           ofs;
  rtc_time_t                  now, shown;
  bcd8_t                      ctl_q, rd_val;
  logic                       commit, pend_q, refresh;
  logic [ALM_FIELDS-1:0][7:0] alm_o;
  logic [1:0]                 ena_q;
  logic                       flag_q, hit;

  assign in_page = (bus_addr >> OFS_W) == '0;
  assign ofs     = bus_addr[OFS_W-1:0];
  assign wr_en   = bus_wr && in_page;
  assign rd_en   = bus_rd && in_page;
  assign flag_rd = rd_en && (ofs == OFS_FLG);
  assign step    = tick_1hz && ctl_q[CTL_RUN] && !commit;

  bcd_rtc_calendar u_cal (
    .clk(clk), .rst(rst), .step(step), .load(commit), .load_val(shown), .now(now)
  );

  bcd_rtc_view u_view (
    .clk(clk), .rst(rst), .wr_en(wr_en), .ofs(ofs), .wdata(bus_wdata),
    .step(step), .now(now), .shown(shown), .ctl_q(ctl_q), .commit(commit),
    .pend_q(pend_q), .refresh(refresh)
  );

  bcd_rtc_alarm u_alm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .ofs(ofs), .wdata(bus_wdata),
    .flag_rd(flag_rd), .check(pend_q), .now(now), .alm_o(alm_o),
    .ena_q(ena_q), .flag_q(flag_q), .hit(hit), .irq_q(alarm_irq)
  );

  always_comb begin
    rd_val = 8'h00;
    case (ofs)
      OFS_SEC:  rd_val = shown.sec;
      OFS_MIN:  rd_val = shown.min;
      OFS_HR:   rd_val = shown.hr;
      OFS_DOW:  rd_val = shown.dow;
      OFS_DOM:  rd_val = shown.dom;
      OFS_MON:  rd_val = shown.mon;
      OFS_YR:   rd_val = shown.yr;
      OFS_CEN:  rd_val = shown.cen;
      OFS_ASEC: rd_val = alm_o[0];
      OFS_AMIN: rd_val = alm_o[1];
      OFS_AHR:  rd_val = alm_o[2];
      OFS_ADOM: rd_val = alm_o[3];
      OFS_ENA:  rd_val = {4'b0000, ena_q, 2'b00};
      OFS_FLG:  rd_val = {4'b0000, flag_q, 3'b000};
      OFS_CTL:  rd_val = ctl_q;
      default:  rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= 8'h00;
    else if (bus_wr || bus_rd) bus_rdata <= rd_en ? rd_val : 8'h00;
  end
endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk
  import bcd_rtc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [OFS_W-1:0] ofs,
  input logic             hold,
  input logic             run,
  input logic             commit,
  input logic             refresh,
  input logic [7:0]       shown_sec,
  input logic [7:0]       now_sec,
  input logic             flag_rd,
  input logic             hit,
  input logic             flag,
  input logic             irq
);
  logic sec_wr;
  assign sec_wr = wr_en && (ofs == OFS_SEC);

  // R4
  hold_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && !refresh && !sec_wr) |=> $stable(shown_sec));

  // R7
  refresh_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (refresh && !sec_wr) |=> (shown_sec == $past(now_sec)));

  // R9
  stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !commit) |=> $stable(now_sec));

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_rd && !hit) |=> !flag);

  // R10
  hit_set_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag);

  // R11
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);
endmodule

bind bcd_rtc bcd_rtc_chk chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .ofs(ofs),
  .hold(ctl_q[3]), .run(ctl_q[2]), .commit(commit), .refresh(refresh),
  .shown_sec(shown.sec), .now_sec(now.sec), .flag_rd(flag_rd), .hit(hit),
  .flag(flag_q), .irq(alarm_irq)
);

// File: tb/bcd_rtc_tb_top.sv
module bcd_rtc_tb_top;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_1hz = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_wdata = 8'h00;
  logic [7:0]    bus_rdata;
  logic          alarm_irq;

  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;
  logic  rd_d = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  bcd_rtc #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .alarm_irq(alarm_irq)
  );

  // monitor: data of a read is valid at the negedge after its sampling edge
  always @(posedge clk) rd_d <= bus_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: read actual=%02h expected=%02h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string t);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic sec_tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (alarm_irq !== e) begin
      errors++;
      $display("FAIL %s: alarm_irq actual=%0b expected=%0b", t, alarm_irq, e);
    end
  endtask

  task automatic set_time(input logic [7:0] cen, yr, mon, dom, dow, hr, mn, sc);
    wr(6'h0E, 8'h0C);
    wr(6'h00, sc); wr(6'h01, mn); wr(6'h02, hr); wr(6'h03, dow);
    wr(6'h04, dom); wr(6'h05, mon); wr(6'h06, yr); wr(6'h07, cen);
    wr(6'h0E, 8'h04);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(6'h00, 8'h00, "R1 sec"); rd(6'h01, 8'h00, "R1 min"); rd(6'h02, 8'h00, "R1 hr");
    rd(6'h03, 8'h01, "R1 dow"); rd(6'h04, 8'h01, "R1 dom"); rd(6'h05, 8'h01, "R1 mon");
    rd(6'h06, 8'h00, "R1 yr");  rd(6'h07, 8'h20, "R1 cen"); rd(6'h0E, 8'h04, "R1 ctl");
    rd(6'h0C, 8'h00, "R1 ena"); rd(6'h0D, 8'h00, "R1 flg"); rd(6'h08, 8'h00, "R1 asec");
    chk_irq(1'b0, "R1 irq");
    // R12 unmapped offsets
    rd(6'h0F, 8'h00, "R12 ofs15");
    wr(6'h10, 8'h33);
    rd(6'h10, 8'h00, "R12 upper page");
    rd(6'h00, 8'h00, "R12 upper write ignored");
    // R2 one second step
    sec_tick();
    rd(6'h00, 8'h01, "R2 sec step");
    // R3 load, R5/R6 roll into March of a non-leap year
    set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h58);
    rd(6'h00, 8'h58, "R3 loaded sec");
    sec_tick();
    rd(6'h00, 8'h59, "R3 counts on");
    sec_tick();
    rd(6'h00, 8'h00, "R5 sec wrap"); rd(6'h01, 8'h00, "R5 min wrap");
    rd(6'h02, 8'h00, "R5 hr wrap");  rd(6'h04, 8'h01, "R6 feb28 wrap");
    rd(6'h05, 8'h03, "R6 month inc"); rd(6'h03, 8'h01, "R6 dow wrap");
    // R6 leap year
    set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    sec_tick();
    rd(6'h04, 8'h29, "R6 leap feb29"); rd(6'h05, 8'h02, "R6 leap month");
    // R6 30-day month
    set_time(8'h20, 8'h23, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    sec_tick();
    rd(6'h04, 8'h01, "R6 apr30 wrap"); rd(6'h05, 8'h05, "R6 may");
    // R5 century carry
    set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    sec_tick();
    rd(6'h07, 8'h21, "R5 century"); rd(6'h06, 8'h00, "R5 year wrap");
    rd(6'h05, 8'h01, "R5 month wrap"); rd(6'h04, 8'h01, "R5 dom"); rd(6'h03, 8'h06, "R5 dow");
    // R4 freeze without writes
    wr(6'h0E, 8'h0C);
    sec_tick(); sec_tick();
    rd(6'h00, 8'h00, "R4 frozen");
    wr(6'h0E, 8'h04);
    rd(6'h00, 8'h00, "R4 no reload on release");
    sec_tick();
    rd(6'h00, 8'h03, "R4 true time");
    // R7 hold set during a reload
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0; bus_addr = 6'h0E; bus_wdata = 8'h0C; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(6'h00, 8'h04, "R7 reload completes");
    sec_tick();
    rd(6'h00, 8'h04, "R7 then frozen");
    wr(6'h0E, 8'h04);
    sec_tick();
    rd(6'h00, 8'h06, "R7 resumes");
    // R8 writes ignored without hold
    wr(6'h00, 8'h30);
    rd(6'h00, 8'h06, "R8 visible untouched");
    sec_tick();
    rd(6'h00, 8'h07, "R8 counter untouched");
    // R9 control bits and stop
    wr(6'h0E, 8'h00);
    rd(6'h0E, 8'h00, "R9 ctl stopped");
    sec_tick();
    rd(6'h00, 8'h07, "R9 stopped");
    wr(6'h0E, 8'h07);
    rd(6'h0E, 8'h07, "R9 dst 24h run");
    sec_tick();
    rd(6'h00, 8'h08, "R9 runs");
    wr(6'h0E, 8'hF4);
    rd(6'h0E, 8'h04, "R9 upper bits 0");
    sec_tick();
    rd(6'h00, 8'h09, "R9 sec 09");
    // R10 / R11 alarm with interrupt enabled
    wr(6'h08, 8'h11); wr(6'h09, 8'h00); wr(6'h0A, 8'h00); wr(6'h0B, 8'h01);
    wr(6'h0C, 8'hFF);
    rd(6'h0C, 8'h0C, "R11 ena bits");
    rd(6'h08, 8'h11, "R10 asec");
    sec_tick();
    chk_irq(1'b0, "R11 no match");
    rd(6'h0D, 8'h00, "R10 no flag");
    sec_tick();
    chk_irq(1'b1, "R11 irq on match");
    rd(6'h0D, 8'h08, "R10 flag set");
    chk_irq(1'b0, "R11 irq drops on read");
    rd(6'h0D, 8'h00, "R10 flag cleared");
    // R11 interrupt disabled, flag still set
    wr(6'h0C, 8'h04);
    wr(6'h08, 8'h12);
    sec_tick();
    chk_irq(1'b0, "R11 masked");
    rd(6'h0D, 8'h08, "R10 flag while masked");
    rd(6'h0D, 8'h00, "R10 cleared again");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: pending reads actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule